// File: doc/BRIEF.md
# Eight-bit Shared-Bus Teaching Processor

This block is a very small accumulator processor. It has two data registers (A and B), an instruction register, a memory address register, a 4-bit program counter, a 16-byte memory, an adder/subtractor with zero and carry flags, and an output register. Every transfer between these parts uses one 8-bit internal bus. A micro-step sequencer chooses exactly one bus source and a set of load strobes in each step.

Each instruction is one byte. The opcode sits in the upper nibble and a 4-bit operand (an address or an immediate) in the lower nibble. Fetch always takes two micro-steps. Execute takes one to three more, and then the sequencer returns to step zero. The machine runs freely while `run` is high. While `run` is low, it advances one micro-step for each rising edge on `step`. A preload port fills memory before a program starts. Results are seen on `out_val`, and `halted` reports that a stop instruction has executed.

Top module: `bus_cpu8`

## Requirements
- R1: After reset, `out_val` is 0 and `halted` is 0. The program counter, the flags and the micro-step counter are 0, so execution starts at address 0.
- R2: Opcodes (upper nibble) are: 0 no-op, 1 load A from memory, 2 add memory, 3 subtract memory, 4 store A, 5 load A with the immediate, 6 jump, 7 jump if carry, 8 jump if zero, E copy A to output, F halt. Any other opcode acts as a no-op.
- R3: A memory load or an immediate load places the operand value in A. The output instruction copies A to `out_val`.
- R4: Add writes A + mem[operand] to A, modulo 256.
- R5: Subtract writes A + ~mem[operand] + 1 to A. The carry out of this sum is the carry flag, so carry = 1 means no borrow.
- R6: Only add and subtract update the flags. Zero is set when the 8-bit result is 0, and carry is set when the 9th sum bit is 1. Jumps and all other instructions leave the flags as they are.
- R7: Jump always loads the program counter with the operand. Jump-if-carry and jump-if-zero do so only when the matching latched flag is 1. Otherwise they fall through to the next address.
- R8: Store writes A into mem[operand].
- R9: Halt raises `halted`. After that, nothing advances and `out_val` keeps its value until reset, even with `run` high.
- R10: With `run` low, each rising edge of `step` advances exactly one micro-step, however long `step` stays high. Load-immediate and output each take three micro-steps: two fetch steps and one execute step.
- R11: At most one source drives the internal bus in any micro-step.
- R12: While `pl_we` is high, `pl_data` is written to memory at `pl_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Free-run enable: advances one micro-step per clock |
| step | input | 1 | Single-step request: a rising edge gives one micro-step while run is low |
| pl_we | input | 1 | Memory preload write enable |
| pl_addr | input | 4 | Memory preload address |
| pl_data | input | 8 | Memory preload data |
| out_val | output | 8 | Output register value |
| halted | output | 1 | High once a halt instruction has executed |

## Verification
The flag-sensitive case is the final add or subtract micro-step. In that one cycle the ALU result is written back to A and the zero and carry flags are latched, and both must come from the old A. Each vector's operands are run twice. One program prints the raw result. A second program uses conditional jumps to turn the latched flag pair into a code and prints that code. The operand pairs are chosen to give both flags together (0x80+0x80, 5-5), carry alone, zero alone, and neither.

// File: rtl/bus_cpu8.sv
module bus_cpu8 #(
  parameter int DW = 8,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          step,
  input  logic          pl_we,
  input  logic [AW-1:0] pl_addr,
  input  logic [DW-1:0] pl_data,
  output logic [DW-1:0] out_val,
  output logic          halted
);
  localparam int OPW   = DW - AW;
  localparam int DEPTH = 1 << AW;
  localparam logic [OPW-1:0] OP_LDA = OPW'(1), OP_ADD = OPW'(2), OP_SUB = OPW'(3),
                             OP_STA = OPW'(4), OP_LDI = OPW'(5), OP_JMP = OPW'(6),
                             OP_JC  = OPW'(7), OP_JZ  = OPW'(8), OP_OUT = OPW'(14),
                             OP_HLT = OPW'(15);

  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] a_q, b_q, ir_q, out_q, bus;
  logic [AW-1:0] pc_q, mar_q;
  logic [2:0]    t_q;
  logic          zf, cf, halt_q, step_q, adv;
  logic          d_pc, d_mem, d_ir, d_a, d_alu;
  logic          l_mar, l_ir, l_a, l_b, l_out, l_pc, l_mem, l_flg, pc_inc, sub, hlt, last;
  logic [DW:0]   sum;
  logic [OPW-1:0] op;

  assign op      = ir_q[DW-1:AW];
  assign adv     = !halt_q && (run || (step && !step_q));
  assign sum     = {1'b0, a_q} + {1'b0, sub ? ~b_q : b_q} + {{DW{1'b0}}, sub};
  assign out_val = out_q;
  assign halted  = halt_q;

  always_comb begin
    bus = '0;
    if (d_pc)  bus = DW'(pc_q);
    if (d_mem) bus = mem[mar_q];
    if (d_ir)  bus = DW'(ir_q[AW-1:0]);
    if (d_a)   bus = a_q;
    if (d_alu) bus = sum[DW-1:0];
  end

  always_comb begin
    {d_pc, d_mem, d_ir, d_a, d_alu} = '0;
    {l_mar, l_ir, l_a, l_b, l_out, l_pc, l_mem, l_flg, pc_inc, sub, hlt, last} = '0;
    case (t_q)
      3'd0: begin d_pc = 1'b1; l_mar = 1'b1; end
      3'd1: begin d_mem = 1'b1; l_ir = 1'b1; pc_inc = 1'b1; end
      default: begin
        case (op)
          OP_LDA:
            if (t_q == 3'd2) begin d_ir = 1'b1; l_mar = 1'b1; end
            else begin d_mem = 1'b1; l_a = 1'b1; last = 1'b1; end
          OP_ADD, OP_SUB:
            if (t_q == 3'd2) begin d_ir = 1'b1; l_mar = 1'b1; end
            else if (t_q == 3'd3) begin d_mem = 1'b1; l_b = 1'b1; end
            else begin
              d_alu = 1'b1; l_a = 1'b1; l_flg = 1'b1; sub = (op == OP_SUB); last = 1'b1;
            end
          OP_STA:
            if (t_q == 3'd2) begin d_ir = 1'b1; l_mar = 1'b1; end
            else begin d_a = 1'b1; l_mem = 1'b1; last = 1'b1; end
          OP_LDI: begin d_ir = 1'b1; l_a = 1'b1; last = 1'b1; end
          OP_JMP: begin d_ir = 1'b1; l_pc = 1'b1; last = 1'b1; end
          OP_JC:  begin d_ir = cf; l_pc = cf; last = 1'b1; end
          OP_JZ:  begin d_ir = zf; l_pc = zf; last = 1'b1; end
          OP_OUT: begin d_a = 1'b1; l_out = 1'b1; last = 1'b1; end
          OP_HLT: begin hlt = 1'b1; last = 1'b1; end
          default: last = 1'b1;
        endcase
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q <= '0; b_q <= '0; ir_q <= '0; out_q <= '0;
      pc_q <= '0; mar_q <= '0; t_q <= '0;
      zf <= 1'b0; cf <= 1'b0; halt_q <= 1'b0; step_q <= 1'b0;
    end else begin
      step_q <= step;
      if (adv) begin
        if (l_mar) mar_q <= bus[AW-1:0];
        if (l_ir)  ir_q  <= bus;
        if (l_a)   a_q   <= bus;
        if (l_b)   b_q   <= bus;
        if (l_out) out_q <= bus;
        if (l_pc)        pc_q <= bus[AW-1:0];
        else if (pc_inc) pc_q <= pc_q + AW'(1);
        if (l_flg) begin
          zf <= (sum[DW-1:0] == '0);
          cf <= sum[DW];
        end
        if (hlt) halt_q <= 1'b1;
        t_q <= last ? 3'd0 : t_q + 3'd1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (pl_we)              mem[pl_addr] <= pl_data;
    else if (adv && l_mem)  mem[mar_q]   <= bus;
  end

  AST_BUS_ONE_DRIVER: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({d_pc, d_mem, d_ir, d_a, d_alu})); // R11
  AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    halt_q |=> halt_q); // R9
  AST_HALT_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    halt_q |=> $stable(out_q) && $stable(pc_q)); // R9
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(t_q) && $stable(pc_q) && $stable(a_q)); // R10
  AST_FETCH_INC: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && t_q == 3'd1) |=> (pc_q == $past(pc_q) + AW'(1))); // R10
  AST_STEP_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    t_q <= 3'd4); // R10
  AST_FLAGS_ALU_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    !(adv && d_alu) |=> $stable({zf, cf})); // R6
endmodule

// File: tb/bus_cpu8_tb.sv
`timescale 1ns/1ps
module bus_cpu8_tb;
  logic clk = 1'b0, rst_n = 1'b0, run = 1'b0, step = 1'b0, pl_we = 1'b0;
  logic [3:0] pl_addr = '0;
  logic [7:0] pl_data = '0;
  logic [7:0] out_val;
  logic halted;
  int n_run = 0, n_fail = 0;
  logic [7:0] prog [16];

  always #2.5 clk = ~clk;

  bus_cpu8 u_dut (.clk(clk), .rst_n(rst_n), .run(run), .step(step), .pl_we(pl_we),
    .pl_addr(pl_addr), .pl_data(pl_data), .out_val(out_val), .halted(halted));

  // {a, b, sub, result, flag code = 2*C + Z}
  localparam logic [39:0] VEC [7] = '{
    40'h05_03_00_08_00, 40'h80_80_00_00_03, 40'hFF_02_00_01_02, 40'h00_00_00_00_01,
    40'h07_03_01_04_02, 40'h03_07_01_FC_00, 40'h05_05_01_00_03 };

  task automatic chk(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear_prog();
    for (int i = 0; i < 16; i++) prog[i] = 8'h00;
  endtask

  task automatic boot();
    @(negedge clk);
    rst_n = 1'b0; run = 1'b0; step = 1'b0;
    for (int i = 0; i < 16; i++) begin
      pl_we = 1'b1; pl_addr = 4'(i); pl_data = prog[i];
      @(negedge clk);
    end
    pl_we = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic run_to_halt();
    bit done = 1'b0;
    run = 1'b1;
    for (int c = 0; c < 500; c++) begin
      @(negedge clk);
      if (halted) begin done = 1'b1; break; end
    end
    run = 1'b0;
    chk(done, "R9 halt reached", {7'd0, halted}, 8'd1);
  endtask

  task automatic pulse(input int hold);
    step = 1'b1;
    repeat (hold) @(negedge clk);
    step = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #(5.0 * 150000);
    n_fail++;
    $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    clear_prog();
    boot();
    chk(out_val == 8'h00, "R1 out after reset", out_val, 8'h00);
    chk(halted == 1'b0, "R1 halted after reset", {7'd0, halted}, 8'd0);

    foreach (VEC[i]) begin
      logic [7:0] va, vb, vs, vr, vc;
      {va, vb, vs, vr, vc} = VEC[i];
      clear_prog();
      prog[0] = 8'h1E; prog[1] = vs[0] ? 8'h3F : 8'h2F; prog[2] = 8'hE0; prog[3] = 8'hF0;
      prog[14] = va; prog[15] = vb;
      boot(); run_to_halt();
      chk(out_val == vr, vs[0] ? "R5 subtract result" : "R4 add result", out_val, vr);
      prog[2] = 8'h78; prog[3] = 8'h86; prog[4] = 8'h50; prog[5] = 8'h6C;
      prog[6] = 8'h51; prog[7] = 8'h6C; prog[8] = 8'h8B; prog[9] = 8'h52;
      prog[10] = 8'h6C; prog[11] = 8'h53; prog[12] = 8'hE0; prog[13] = 8'hF0;
      boot(); run_to_halt();
      chk(out_val == vc, "R6 R7 latched flags via conditional jumps", out_val, vc);
    end

    clear_prog();
    prog[0] = 8'hA5; prog[1] = 8'h00; prog[2] = 8'h5C; prog[3] = 8'hE0; prog[4] = 8'hF0;
    boot(); run_to_halt();
    chk(out_val == 8'h0C, "R2 undefined opcode as no-op, R3 immediate", out_val, 8'h0C);

    // R11: store then reload moves A->memory->A over the bus
    clear_prog();
    prog[0] = 8'h59; prog[1] = 8'h4E; prog[2] = 8'h50; prog[3] = 8'h1E; prog[4] = 8'hE0; prog[5] = 8'hF0;
    boot(); run_to_halt();
    chk(out_val == 8'h09, "R8 R12 store and reload", out_val, 8'h09);

    clear_prog();
    prog[0] = 8'h51; prog[1] = 8'h63; prog[2] = 8'h57; prog[3] = 8'hE0; prog[4] = 8'hF0;
    boot(); run_to_halt();
    chk(out_val == 8'h01, "R7 unconditional jump", out_val, 8'h01);

    clear_prog();
    prog[0] = 8'h51; prog[1] = 8'h75; prog[2] = 8'h85; prog[3] = 8'hE0; prog[4] = 8'hF0;
    prog[5] = 8'h57; prog[6] = 8'hE0; prog[7] = 8'hF0;
    boot(); run_to_halt();
    chk(out_val == 8'h01, "R7 conditional jumps not taken on clear flags", out_val, 8'h01);

    clear_prog();
    prog[0] = 8'h53; prog[1] = 8'hE0; prog[2] = 8'hF0; prog[3] = 8'h54; prog[4] = 8'hE0;
    boot(); run_to_halt();
    run = 1'b1;
    repeat (30) @(negedge clk);
    run = 1'b0;
    chk(out_val == 8'h03, "R9 output frozen after halt", out_val, 8'h03);
    chk(halted == 1'b1, "R9 halted stays high", {7'd0, halted}, 8'd1);
    @(negedge clk); rst_n = 1'b0; @(negedge clk); rst_n = 1'b1; @(negedge clk);
    chk(halted == 1'b0 && out_val == 8'h00, "R1 reset clears halt and output", out_val, 8'h00);

    clear_prog();
    prog[0] = 8'h57; prog[1] = 8'hE0; prog[2] = 8'hF0;
    boot();
    repeat (5) pulse(1);
    repeat (10) @(negedge clk);
    chk(out_val == 8'h00, "R10 five micro-steps do not reach output", out_val, 8'h00);
    pulse(6);
    chk(out_val == 8'h07, "R10 sixth micro-step loads output", out_val, 8'h07);
    repeat (2) pulse(4);
    chk(halted == 1'b0, "R10 long pulses give one step each", {7'd0, halted}, 8'd0);
    pulse(1);
    chk(halted == 1'b1, "R10 ninth micro-step halts", {7'd0, halted}, 8'd1);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule